// File: doc/BRIEF.md
# Forecasting Virtual-Channel Activation Controller

This block sits beside one router input port. It decides how many of the port's virtual-channel buffers stay clocked during the next observation window. Time is cut into back-to-back windows of a fixed number of cycles. In each window the block counts two things: the cycles in which a flit crosses the input link, and, for each virtual channel, the cycles in which that channel is locked to a packet.

When a window closes, the two counts are merged into one traffic figure in unsigned fixed point. That figure is blended with the forecast from the previous window through an exponential filter, using only constant multiplies and shifts. The new forecast is kept as the "past" value for the next window.

A decision step then moves the required channel count up by one, down by one, or leaves it where it is. From that count the block builds a per-channel enable mask, which drives the clock gates of the channel buffers. A channel that is still locked keeps its enable until the lock drops, so a packet is never stranded in a buffer whose clock has stopped.

Top module: `dvc_activation_ctrl`

## Requirements
- R1: While `rst` is high, and until the first window closes, `req_count` is 1 and `vc_enable` is 0b0001. The forecast register holds 0.
- R2: A window spans `WIN_CYC` (4) rising edges after reset. `req_count` changes only on the edge that closes a window.
- R3: The window traffic figure is (link-active cycles + the sum of locked cycles over all channels) divided by 2·`NUM_VC`·`WIN_CYC`. It is expressed with `FRAC` (8) fractional bits, where 1.0 = 256, and truncated toward zero.
- R4: The new forecast is (12·traffic + 4·past) / 16, truncated and capped at 256. It becomes the past value for the next window.
- R5: At a window close with current count k, the count becomes k+1 when k < `NUM_VC`, the new forecast is strictly greater than the past forecast, and the new forecast is strictly greater than k·32 (k/(2·`NUM_VC`) of full scale).
- R6: At a window close with current count k, the count becomes k−1 when k > 1, the new forecast is strictly below the past forecast, and the new forecast is strictly below (k−1)·32.
- R7: `req_count` always lies in 1..`NUM_VC`. It moves by at most one per window.
- R8: Bit i of `vc_enable` is 1 whenever i < `req_count`. Both outputs update on the same edge.
- R9: Bit i of `vc_enable` with i ≥ `req_count` stays 1 while `vc_lock[i]` is 1, provided it was already 1. It drops on the first edge at which that lock bit is sampled 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_act | input | 1 | High in a cycle in which a flit crosses the input link |
| vc_lock | input | NUM_VC | Bit i high while virtual channel i is locked to a packet |
| req_count | output | $clog2(NUM_VC+1) | Number of virtual channels required for the current window |
| vc_enable | output | NUM_VC | Clock-enable per virtual-channel buffer |

## Verification
The hardest case to reach from the ports is a lock holding up a channel above the required count. To get there, the forecast is first driven up until all four channels are enabled. Link traffic then stops while locks stay asserted on the two top channels, so the count falls under them. The locks are released one at a time, and the stimulus checks that each enable bit drops only after its own lock clears. Before that, a sweep covers every combination of link-activity count and per-channel lock count within a window. Each combination is held for several windows so the filter reaches its rise and fall conditions. An arithmetic model of the filter and the thresholds predicts the outputs on every cycle.

// File: rtl/dvc_pkg.sv
package dvc_pkg;

  // Outcome of the per-window decision step.
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  // Width needed to count from 0 to v inclusive.
  function automatic int count_w(input int v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/dvc_window_meter.sv
module dvc_window_meter #(
  parameter int NUM_VC  = 4,
  parameter int WIN_CYC = 4,
  parameter int SUMW    = dvc_pkg::count_w((NUM_VC + 1) * WIN_CYC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_act,
  input  logic [NUM_VC-1:0] vc_lock,
  output logic              win_end,
  output logic [SUMW-1:0]   win_total
);
  localparam int PHW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam int CW  = dvc_pkg::count_w(WIN_CYC);

  logic [PHW-1:0] phase_q;
  logic [CW-1:0]  link_cnt_q;
  logic [CW-1:0]  lock_cnt_q [NUM_VC];

  assign win_end = (phase_q == PHW'(WIN_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || win_end) phase_q <= '0;
    else                phase_q <= phase_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || win_end) link_cnt_q <= '0;
    else                link_cnt_q <= link_cnt_q + CW'(link_act);
  end

  for (genvar g = 0; g < NUM_VC; g++) begin : g_lock
    always_ff @(posedge clk) begin
      if (rst || win_end) lock_cnt_q[g] <= '0;
      else                lock_cnt_q[g] <= lock_cnt_q[g] + CW'(vc_lock[g]);
    end

    // R3: a per-channel count never reaches the window length before closing
    lock_cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
      int'(lock_cnt_q[g]) < WIN_CYC);
  end

  // Window total includes the current (closing) cycle's inputs.
  always_comb begin
    win_total = SUMW'(link_cnt_q) + SUMW'(link_act);
    for (int i = 0; i < NUM_VC; i++)
      win_total = win_total + SUMW'(lock_cnt_q[i]) + SUMW'(vc_lock[i]);
  end

  // R2: the window phase returns to zero right after a closing edge
  win_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    win_end |=> (phase_q == '0));
endmodule

// File: rtl/dvc_forecast.sv
module dvc_forecast #(
  parameter int NUM_VC   = 4,
  parameter int WIN_CYC  = 4,
  parameter int FRAC     = 8,
  parameter int ALPHA_Q  = 12,
  parameter int ALPHA_SH = 4,
  parameter int SUMW     = dvc_pkg::count_w((NUM_VC + 1) * WIN_CYC),
  parameter int FW       = FRAC + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            win_end,
  input  logic [SUMW-1:0] win_total,
  output logic [FW-1:0]   pred_next,
  output logic [FW-1:0]   past_q
);
  localparam int NH_SH = $clog2(NUM_VC * WIN_CYC);
  localparam int SCW   = SUMW + FRAC;
  localparam int BW    = FW + ALPHA_SH + 1;
  localparam logic [FW-1:0] ONE = FW'(1) << FRAC;

  logic [SCW-1:0] scaled;
  logic [FW-1:0]  act;
  logic [BW-1:0]  blend;
  logic [BW-1:0]  blend_sh;

  // traffic = (link + locks) / (2 * n * H), in Q.FRAC
  assign scaled = {win_total, {FRAC{1'b0}}} >> (NH_SH + 1);
  assign act    = (scaled > SCW'(ONE)) ? ONE : scaled[FW-1:0];

  // exponential filter with constant weights (shift-and-add multipliers)
  assign blend    = BW'(ALPHA_Q) * BW'(act)
                  + BW'((1 << ALPHA_SH) - ALPHA_Q) * BW'(past_q);
  assign blend_sh = blend >> ALPHA_SH;
  assign pred_next = (blend_sh > BW'(ONE)) ? ONE : blend_sh[FW-1:0];

  always_ff @(posedge clk) begin
    if (rst)          past_q <= '0;
    else if (win_end) past_q <= pred_next;
  end

  // R4: stored forecast never exceeds full scale
  past_range_chk: assert property (@(posedge clk) disable iff (rst)
    past_q <= ONE);

  // R4: stored forecast is held between window closes
  past_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> $stable(past_q));
endmodule

// File: rtl/dvc_decide.sv
module dvc_decide #(
  parameter int NUM_VC = 4,
  parameter int FRAC   = 8,
  parameter int FW     = FRAC + 1,
  parameter int RW     = dvc_pkg::count_w(NUM_VC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_end,
  input  logic [FW-1:0]     pred_next,
  input  logic [FW-1:0]     past_q,
  input  logic [NUM_VC-1:0] vc_lock,
  output logic [RW-1:0]     req_q,
  output logic [NUM_VC-1:0] en_q
);
  import dvc_pkg::*;

  // step of one count = 1 / (2 * NUM_VC) of full scale
  localparam int TSH = FRAC - $clog2(NUM_VC) - 1;

  logic [FW-1:0]     up_thr;
  logic [FW-1:0]     dn_thr;
  step_e             step;
  logic [RW-1:0]     req_d;
  logic [NUM_VC-1:0] en_d;

  assign up_thr = FW'(req_q) << TSH;
  assign dn_thr = FW'(req_q - 1'b1) << TSH;

  always_comb begin
    step = STEP_HOLD;
    if (win_end) begin
      if (pred_next > past_q && pred_next > up_thr && int'(req_q) < NUM_VC)
        step = STEP_UP;
      else if (pred_next < past_q && pred_next < dn_thr && req_q > RW'(1))
        step = STEP_DOWN;
    end
  end

  always_comb begin
    unique case (step)
      STEP_UP:   req_d = req_q + 1'b1;
      STEP_DOWN: req_d = req_q - 1'b1;
      default:   req_d = req_q;
    endcase
  end

  for (genvar g = 0; g < NUM_VC; g++) begin : g_en
    assign en_d[g] = (int'(req_d) > g) || (en_q[g] && vc_lock[g]);

    // R9: a locked channel that is enabled stays enabled
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (en_q[g] && vc_lock[g]) |=> en_q[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= RW'(1);
      en_q  <= NUM_VC'(1);
    end else begin
      req_q <= req_d;
      en_q  <= en_d;
    end
  end

  // R7: count stays inside 1..NUM_VC
  req_range_chk: assert property (@(posedge clk) disable iff (rst)
    req_q >= RW'(1) && int'(req_q) <= NUM_VC);

  // R7: count moves by at most one per edge
  req_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (req_q == $past(req_q) || req_q == $past(req_q) + 1'b1
              || req_q == $past(req_q) - 1'b1));

  // R2: count is frozen except on a window-closing edge
  req_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> $stable(req_q));

  // R8: at least req_q channels are enabled
  en_cover_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(en_q) >= int'(req_q));
endmodule

// File: rtl/dvc_activation_ctrl.sv
module dvc_activation_ctrl #(
  parameter int NUM_VC   = 4,
  parameter int WIN_CYC  = 4,
  parameter int FRAC     = 8,
  parameter int ALPHA_Q  = 12,
  parameter int ALPHA_SH = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          link_act,
  input  logic [NUM_VC-1:0]             vc_lock,
  output logic [$clog2(NUM_VC+1)-1:0]   req_count,
  output logic [NUM_VC-1:0]             vc_enable
);
  localparam int SUMW = dvc_pkg::count_w((NUM_VC + 1) * WIN_CYC);
  localparam int FW   = FRAC + 1;
  localparam int RW   = $clog2(NUM_VC + 1);

  logic            win_end;
  logic [SUMW-1:0] win_total;
  logic [FW-1:0]   pred_next;
  logic [FW-1:0]   past_q;

  dvc_window_meter #(
    .NUM_VC (NUM_VC),
    .WIN_CYC(WIN_CYC),
    .SUMW   (SUMW)
  ) u_meter (
    .clk      (clk),
    .rst      (rst),
    .link_act (link_act),
    .vc_lock  (vc_lock),
    .win_end  (win_end),
    .win_total(win_total)
  );

  dvc_forecast #(
    .NUM_VC  (NUM_VC),
    .WIN_CYC (WIN_CYC),
    .FRAC    (FRAC),
    .ALPHA_Q (ALPHA_Q),
    .ALPHA_SH(ALPHA_SH),
    .SUMW    (SUMW),
    .FW      (FW)
  ) u_forecast (
    .clk      (clk),
    .rst      (rst),
    .win_end  (win_end),
    .win_total(win_total),
    .pred_next(pred_next),
    .past_q   (past_q)
  );

  dvc_decide #(
    .NUM_VC(NUM_VC),
    .FRAC  (FRAC),
    .FW    (FW),
    .RW    (RW)
  ) u_decide (
    .clk      (clk),
    .rst      (rst),
    .win_end  (win_end),
    .pred_next(pred_next),
    .past_q   (past_q),
    .vc_lock  (vc_lock),
    .req_q    (req_count),
    .en_q     (vc_enable)
  );
endmodule

// File: tb/tb_dvc_activation_ctrl.sv
module tb_dvc_activation_ctrl;
  localparam int NVC  = 4;
  localparam int WIN  = 4;
  localparam int FRAC = 8;
  localparam int ONE  = 1 << FRAC;
  localparam int STEP = ONE / (2 * NVC);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           link_act = 1'b0;
  logic [NVC-1:0] vc_lock = '0;
  logic [2:0]     req_count;
  logic [NVC-1:0] vc_enable;

  int n_chk = 0;
  int n_bad = 0;

  int m_req = 1;
  int m_past = 0;
  int m_sum = 0;
  int m_phase = 0;
  logic [NVC-1:0] m_en = 4'b0001;

  dvc_activation_ctrl dut (
    .clk      (clk),
    .rst      (rst),
    .link_act (link_act),
    .vc_lock  (vc_lock),
    .req_count(req_count),
    .vc_enable(vc_enable)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // arithmetic model taken from the requirements
  task automatic model_step(input logic lk, input logic [NVC-1:0] lck);
    int act, pred, nreq;
    m_sum += int'(lk) + $countones(lck);
    if (m_phase == WIN - 1) begin
      act = (m_sum * ONE) / (2 * NVC * WIN);
      if (act > ONE) act = ONE;
      pred = (12 * act + 4 * m_past) / 16;
      if (pred > ONE) pred = ONE;
      nreq = m_req;
      if (pred > m_past && pred > m_req * STEP && m_req < NVC) nreq = m_req + 1;
      else if (pred < m_past && pred < (m_req - 1) * STEP && m_req > 1) nreq = m_req - 1;
      m_past = pred;
      m_req = nreq;
      m_sum = 0;
      m_phase = 0;
    end else begin
      m_phase++;
    end
    for (int i = 0; i < NVC; i++)
      m_en[i] = (i < m_req) || (m_en[i] && lck[i]);
  endtask

  task automatic cyc(input logic lk, input logic [NVC-1:0] lck);
    link_act = lk;
    vc_lock = lck;
    @(posedge clk);
    model_step(lk, lck);
    @(negedge clk);
    check("R2/R3/R4/R5/R6/R7 req_count", int'(req_count), m_req);
    check("R8/R9 vc_enable", int'(vc_enable), int'(m_en));
  endtask

  // nl link cycles, each channel locked for s cycles (staggered), plus held locks
  task automatic run_window(input int nl, input int s, input logic [NVC-1:0] hold);
    for (int c = 0; c < WIN; c++) begin
      logic [NVC-1:0] lk;
      for (int i = 0; i < NVC; i++)
        lk[i] = (((c + i) % WIN) < s) || hold[i];
      cyc(c < nl, lk);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 req_count in reset", int'(req_count), 1);
    check("R1 vc_enable in reset", int'(vc_enable), 1);
    rst = 1'b0;
    // sweep every link count and lock count
    for (int nl = 0; nl <= WIN; nl++)
      for (int s = 0; s <= WIN; s++)
        for (int r = 0; r < 3; r++)
          run_window(nl, s, '0);
    // idle traffic: count decays to the minimum
    for (int w = 0; w < 10; w++) run_window(0, 0, '0);
    check("R6 count at minimum after idle", int'(req_count), 1);
    check("R8 single channel enabled after idle", int'(vc_enable), 1);
    // full traffic: count climbs to the maximum
    for (int w = 0; w < 8; w++) run_window(WIN, WIN, '0);
    check("R5 count at maximum after load", int'(req_count), NVC);
    check("R8 all channels enabled", int'(vc_enable), 15);
    // hold the two top channels locked while traffic stops
    for (int w = 0; w < 4; w++) run_window(0, 0, 4'b1100);
    check("R9 top channel held by lock", int'(vc_enable[3]), 1);
    check("R9 count below max while held", int'(req_count < 3'(NVC)), 1);
    // release channel 2 only
    for (int w = 0; w < 4; w++) run_window(0, 0, 4'b1000);
    check("R9 channel 3 still held", int'(vc_enable[3]), 1);
    // release everything
    for (int w = 0; w < 8; w++) run_window(0, 0, '0);
    check("R9 channel 3 released", int'(vc_enable[3]), 0);
    // final mixed pattern
    for (int w = 0; w < 6; w++) run_window(w % (WIN + 1), (w * 3) % (WIN + 1), 4'(w & 1));
    summary();
  end
endmodule